// File: doc/BRIEF.md
# Dynamic Bus-Sizing Address Decoder

This block sits between a microcontroller's multiplexed address/data bus and its external devices. An address strobe (`ale`) captures the address from the shared bus into a holding register. The register keeps that address steady while the same wires carry data. The top latched address bit splits the map into two halves. The lower half is a read-only program store that returns full 16-bit words. The upper half is a memory-mapped I/O window that is read and written one byte at a time.

On each bus cycle the decoder chooses the data width from the top address bit. For an access to the I/O window it also holds the ready line low for one clock, which gives the slower byte-wide ports a wait state. Program fetches run with no wait. While the address points at program space, the I/O buffer enables stay off, so the ports are isolated from the bus. All outputs come from registers clocked by `clk`. Bus strobes are active low and are sampled on rising clock edges.

Top module: `bus_size_decoder`

## Requirements
- R1: At a clock edge where `ale` is high, `addr_q` takes the value on `ad`, so the latch follows the bus while the strobe is high.
- R2: At a clock edge where `ale` is low, `addr_q` keeps its value whatever `ad` carries.
- R3: When `addr_q[15]` is 0, `prog_cs` is high, `byte_mode` is low (16-bit width), and `prog_oe` is high in the cycle after an edge that sampled `rd_n` low.
- R4: A write (`wr_n` low) while `addr_q[15]` is 0 raises none of `prog_oe`, `io_rd_en` or `io_wr_en`, because the program region is read-only.
- R5: While `addr_q[15]` is 0, `io_rd_en` and `io_wr_en` stay low, so the I/O buffers stay in tri-state.
- R6: `byte_mode` is high exactly when `addr_q[15]` is 1, selecting the 8-bit bus width.
- R7: `ready` is low for exactly one clock, in the cycle after the first edge that samples `rd_n` or `wr_n` low while `addr_q[15]` is 1. At all other times `ready` is high, including during program accesses.
- R8: When `addr_q[15]` is 1, `io_rd_en` is high in the cycle after an edge that sampled `rd_n` low, and `io_wr_en` is high in the cycle after an edge that sampled `wr_n` low.
- R9: A clock edge with `rst` high clears `addr_q` to 0, drops all enables, and sets `ready` high, even in the middle of a wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe, latch transparent while high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad | input | 16 | Multiplexed address/data bus |
| addr_q | output | 16 | Latched address |
| prog_cs | output | 1 | Program memory select |
| prog_oe | output | 1 | Program memory output enable |
| io_rd_en | output | 1 | I/O read buffer enable |
| io_wr_en | output | 1 | I/O write strobe enable |
| byte_mode | output | 1 | High selects 8-bit bus width |
| ready | output | 1 | Low inserts a wait state |

## Verification
The assertions assume the bus protocol is followed. `rd_n` and `wr_n` are never low together. The address is latched with both strobes high. Each strobe goes high again before `ale` rises for the next cycle, so the region bit never changes under an active strobe. The stimulus keeps to this by building every access in the same order: address phase, then an idle cycle with the latch closed and junk on `ad`, then a two-clock strobe, then release. The one exception is a reset applied while a strobe is held low, which checks that reset overrides a wait state.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;

  function automatic logic any_strobe(strobe_t s);
    return s.rd | s.wr;
  endfunction
endpackage

// File: rtl/bsd_addr_latch.sv
module bsd_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [ADDR_W-1:0] ad,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (ale) addr_q <= ad;
  end

  a_r1_follow: assert property (@(posedge clk) disable iff (rst)
    ale |=> addr_q == $past(ad));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr_q));
endmodule

// File: rtl/bsd_region_decode.sv
module bsd_region_decode
  import bsd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rd_n,
  input  logic    wr_n,
  input  logic    region_hi,
  output logic    prog_cs,
  output logic    prog_oe,
  output logic    io_rd_en,
  output logic    io_wr_en,
  output logic    byte_mode
);
  strobe_t act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= '{rd: 1'b0, wr: 1'b0};
    else     act_q <= '{rd: ~rd_n, wr: ~wr_n};
  end

  always_comb begin
    prog_cs   = ~region_hi;
    byte_mode = region_hi;
    prog_oe   = ~region_hi & act_q.rd;
    io_rd_en  = region_hi & act_q.rd;
    io_wr_en  = region_hi & act_q.wr;
  end

  // R4/R5: no enable but the program output enable in the low region
  a_r5_isolated: assert property (@(posedge clk) disable iff (rst)
    !region_hi |-> !io_rd_en && !io_wr_en);
  a_r4_prog_read_only: assert property (@(posedge clk) disable iff (rst)
    prog_oe |-> $past(!rd_n));
  a_r8_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_oe, io_rd_en, io_wr_en}));
endmodule

// File: rtl/bsd_wait_gen.sv
module bsd_wait_gen #(
  parameter int WAIT_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_act,
  input  logic region_hi,
  output logic ready
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             strb_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      strb_prev_q <= 1'b0;
    end else begin
      strb_prev_q <= strobe_act;
      if (strobe_act && !strb_prev_q && region_hi)
        cnt_q <= CNT_W'(WAIT_CYCLES);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = (cnt_q == '0);

  a_r7_wait_only_io: assert property (@(posedge clk) disable iff (rst)
    !ready |-> region_hi);
  a_r7_wait_ends: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(1)) |=> ready);
endmodule

// File: rtl/bus_size_decoder.sv
module bus_size_decoder #(
  parameter int ADDR_W      = 16,
  parameter int WAIT_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] ad,
  output logic [ADDR_W-1:0] addr_q,
  output logic              prog_cs,
  output logic              prog_oe,
  output logic              io_rd_en,
  output logic              io_wr_en,
  output logic              byte_mode,
  output logic              ready
);
  localparam int REGION_BIT = ADDR_W - 1;

  logic region_hi;

  bsd_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad(ad), .addr_q(addr_q)
  );

  assign region_hi = addr_q[REGION_BIT];

  bsd_region_decode u_dec (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .region_hi(region_hi),
    .prog_cs(prog_cs), .prog_oe(prog_oe), .io_rd_en(io_rd_en),
    .io_wr_en(io_wr_en), .byte_mode(byte_mode)
  );

  bsd_wait_gen #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst(rst), .strobe_act(~rd_n | ~wr_n),
    .region_hi(region_hi), .ready(ready)
  );

  a_r6_width: assert property (@(posedge clk) disable iff (rst)
    byte_mode == addr_q[REGION_BIT]);
  a_r9_reset: assert property (@(posedge clk)
    rst |=> addr_q == '0 && ready && !io_rd_en && !io_wr_en && !prog_oe);
endmodule

// File: tb/bus_size_decoder_tb.sv
`timescale 1ns/1ps
module bus_size_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] ad = '0;
  logic [15:0] addr_q;
  logic        prog_cs, prog_oe, io_rd_en, io_wr_en, byte_mode, ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_size_decoder u_dut (
    .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad(ad),
    .addr_q(addr_q), .prog_cs(prog_cs), .prog_oe(prog_oe),
    .io_rd_en(io_rd_en), .io_wr_en(io_wr_en), .byte_mode(byte_mode),
    .ready(ready)
  );

  // {is_write, address}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 16'h0000}, {1'b0, 16'h7FFF}, {1'b0, 16'h8000}, {1'b1, 16'h8000},
    {1'b1, 16'hFFFF}, {1'b1, 16'h1234}, {1'b0, 16'hC0A5}, {1'b1, 16'h7FFE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic w);
    logic io;
    io = a[15];
    @(negedge clk); ale = 1'b1; ad = a; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); ale = 1'b0; ad = ~a;
    @(negedge clk);
    chk("R2 addr held", addr_q, a);
    chk("R3 prog_cs", prog_cs, !io);
    chk("R6 byte_mode", byte_mode, io);
    chk("R7 ready idle", ready, 1'b1);
    if (w) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk);
    chk("R7 ready wait", ready, !io);
    chk("R3 R4 prog_oe", prog_oe, !io && !w);
    chk("R8 R5 io_rd_en", io_rd_en, io && !w);
    chk("R8 R5 io_wr_en", io_wr_en, io && w);
    @(negedge clk);
    chk("R7 ready back", ready, 1'b1);
    chk("R8 R5 io_wr_en held", io_wr_en, io && w);
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk("R8 enables off", {prog_oe, io_rd_en, io_wr_en}, 3'b000);
  endtask

  initial begin
    ale = 1'b1; ad = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 addr", addr_q, 16'h0000);
    chk("R9 ready", ready, 1'b1);
    chk("R9 enables", {prog_oe, io_rd_en, io_wr_en}, 3'b000);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) access(VEC[i][15:0], VEC[i][16]);
    // R1 transparency
    @(negedge clk); ale = 1'b1; ad = 16'hA5A5;
    @(negedge clk); chk("R1 follow a", addr_q, 16'hA5A5); ad = 16'h1357;
    @(negedge clk); chk("R1 follow b", addr_q, 16'h1357); ale = 1'b0; ad = 16'hFFFF;
    @(negedge clk); chk("R2 hold", addr_q, 16'h1357);
    // R9 reset during a wait state
    @(negedge clk); ale = 1'b1; ad = 16'h9000;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); chk("R7 wait before reset", ready, 1'b0); rst = 1'b1;
    @(negedge clk);
    chk("R9 ready in wait", ready, 1'b1);
    chk("R9 addr in wait", addr_q, 16'h0000);
    chk("R9 io_rd_en", io_rd_en, 1'b0);
    rst = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule